// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous memory of 18-bit words, each made of two 9-bit lanes, built for a shared data bus that never needs a turnaround gap. Commands, addresses and chip enables are registered on the rising clock edge. Read data flows out during the cycle after its command. Write data follows its command by one edge. A read and a write can therefore alternate on consecutive edges with no idle slot.

The bidirectional bus is split into `din`, `dout` and a drive flag `dout_oe`. A controller state machine tracks what the current cycle holds: a read data phase (`PH_READ`), a write data phase (`PH_WRITE`) or nothing (`PH_IDLE`). There are three transitions. *Load* happens on an enabled edge with `load_n` low: it goes to `PH_READ` or `PH_WRITE` when selected, and to `PH_IDLE` when not. *Continue* happens on an enabled edge with `load_n` high: it keeps the current phase and takes the next address from `addr`, as an external burst address generator supplies it. *Hold* happens on an edge with `clk_en_n` high: nothing moves.

Captured write data goes into a one-entry write buffer. The buffer is committed to the array when the next write data is captured. Reads overlay the buffer contents lane by lane when the addresses match.

Top module: `lw_sram`

## Requirements
- R1: On an edge with `clk_en_n`=0, `load_n`=0, `cs_a_n`=0, `cs_b`=1, `cs_c_n`=0 and `wr_n`=1, a read of `addr` is registered. During the following cycle `dout` carries that word and `dout_oe`=1, provided `out_en_n`=0.
- R2: With `wr_n`=0 under the same select conditions, a write of `addr` is registered. The word on `din` and the lane enables `lane_we_n` present at the next enabled edge are stored. A new command is accepted on that same edge.
- R3: `lane_we_n[0]` (active low) governs bits 8:0 and `lane_we_n[1]` governs bits 17:9. A lane whose enable is high keeps its previous contents.
- R4: A write data edge with `lane_we_n`=2'b11 stores nothing.
- R5: An edge with `clk_en_n`=1 is ignored. Phase and address hold, no write is stored, and a pending write data phase waits for the next enabled edge.
- R6: Throughout a write data phase, `dout_oe`=0 whatever `out_en_n` is.
- R7: After reset, and in the cycle after a load edge where any chip enable is inactive, `dout_oe`=0.
- R8: `out_en_n`=1 forces `dout_oe`=0. Whenever `dout_oe`=0, `dout` is all zeros.
- R9: On an enabled edge with `load_n`=1, the previous phase type continues at the address on `addr`, and the chip enables and `wr_n` are ignored. Continuing from idle stays idle.
- R10: A read of the address whose write data was captured on the same or an earlier edge returns the newly merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high holds everything |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low: load a new command; high: continue the current one |
| wr_n | input | 1 | Low: write, high: read (sampled on load edges) |
| lane_we_n | input | 2 | Per-lane write enables, active low, sampled on the write data edge |
| out_en_n | input | 1 | Output enable, active low, not registered |
| addr | input | AW | Word address |
| din | input | 18 | Write data from the bus |
| dout | output | 18 | Read data to the bus, zero when not driving |
| dout_oe | output | 1 | High while the block drives the bus |

## Verification
Two functions can land on the same edge: the capture of write data into the buffer, and the registration of a read of that very address. The bench provokes this by following a write command directly with a read of the same address, so the data edge and the read command coincide. Some of these writes are partial, so the read must mix buffered lanes with array lanes. The returned word is compared with a reference memory kept in the bench and merged per lane. The same word is read again after a later write has forced the commit, and the two results must agree.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en_n,
    input  logic          cs_a_n,
    input  logic          cs_b,
    input  logic          cs_c_n,
    input  logic          load_n,
    input  logic          wr_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr,
    output phase_e        phase,
    output logic [AW-1:0] cmd_addr,
    output logic          capture,
    output logic          drive
);
    phase_e phase_nxt;
    logic   selected;

    assign selected = !cs_a_n && cs_b && !cs_c_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cmd_addr <= '0;
        end else if (!clk_en_n) begin
            phase    <= phase_nxt;
            cmd_addr <= addr;
        end
    end

    // transitions: load, continue, hold
    always_comb begin
        phase_nxt = phase;
        if (!load_n) begin
            if (!selected)  phase_nxt = PH_IDLE;
            else if (wr_n)  phase_nxt = PH_READ;
            else            phase_nxt = PH_WRITE;
        end else begin
            unique case (phase)
                PH_IDLE:  phase_nxt = PH_IDLE;
                PH_READ:  phase_nxt = PH_READ;
                PH_WRITE: phase_nxt = PH_WRITE;
                default:  phase_nxt = PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        drive   = 1'b0;
        capture = 1'b0;
        unique case (phase)
            PH_IDLE:  ;
            PH_READ:  drive   = !out_en_n;
            PH_WRITE: capture = !clk_en_n;
            default:  ;
        endcase
    end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [WORD_W-1:0] din,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              commit_en,
    output logic [AW-1:0]     commit_addr,
    output logic [WORD_W-1:0] commit_data,
    output logic [LANES-1:0]  commit_mask,
    output logic [WORD_W-1:0] rd_merged
);
    logic              buf_vld;
    logic [AW-1:0]     buf_addr;
    logic [WORD_W-1:0] buf_data;
    logic [LANES-1:0]  buf_mask;
    logic              take;
    logic              hit;

    assign take        = capture && (lane_we_n != {LANES{1'b1}});
    assign commit_en   = take && buf_vld;
    assign commit_addr = buf_addr;
    assign commit_data = buf_data;
    assign commit_mask = buf_mask;
    assign hit         = buf_vld && (buf_addr == cmd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_vld  <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
            buf_mask <= '0;
        end else if (take) begin
            buf_vld  <= 1'b1;
            buf_addr <= cmd_addr;
            buf_data <= din;
            buf_mask <= ~lane_we_n;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign rd_merged[l*LANE_W +: LANE_W] = (hit && buf_mask[l])
            ? buf_data[l*LANE_W +: LANE_W]
            : arr_rdata[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end

        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic [1:0]        lane_we_n,
    input  logic              out_en_n,
    input  logic [AW-1:0]     addr,
    input  logic [17:0]       din,
    output logic [17:0]       dout,
    output logic              dout_oe
);
    phase_e            phase;
    logic [AW-1:0]     cmd_addr;
    logic              capture;
    logic              drive;
    logic              commit_en;
    logic [AW-1:0]     commit_addr;
    logic [WORD_W-1:0] commit_data;
    logic [LANES-1:0]  commit_mask;
    logic [WORD_W-1:0] arr_rdata;
    logic [WORD_W-1:0] rd_merged;

    lw_sram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .load_n(load_n), .wr_n(wr_n), .out_en_n(out_en_n),
        .addr(addr), .phase(phase), .cmd_addr(cmd_addr),
        .capture(capture), .drive(drive)
    );

    lw_sram_wbuf #(.AW(AW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .lane_we_n(lane_we_n), .din(din), .cmd_addr(cmd_addr),
        .arr_rdata(arr_rdata), .commit_en(commit_en),
        .commit_addr(commit_addr), .commit_data(commit_data),
        .commit_mask(commit_mask), .rd_merged(rd_merged)
    );

    lw_sram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr),
        .wr_data(commit_data), .wr_mask(commit_mask),
        .rd_addr(cmd_addr), .rd_data(arr_rdata)
    );

    assign dout_oe = drive;
    assign dout    = drive ? rd_merged : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          cs_a_n,
    input logic          cs_b,
    input logic          cs_c_n,
    input logic          load_n,
    input logic          wr_n,
    input logic          out_en_n,
    input logic          dout_oe,
    input logic [17:0]   dout,
    input logic [1:0]    phase,
    input logic [AW-1:0] cmd_addr
);
    logic sel;
    assign sel = !cs_a_n && cs_b && !cs_c_n;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && sel && wr_n) |=> (dout_oe == !out_en_n)); // R1

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && sel && !wr_n) |=> !dout_oe); // R6

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !sel) |=> !dout_oe); // R7

    AST_OE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_oe); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == 18'h0)); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(phase) && $stable(cmd_addr))); // R5

    AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> (phase == $past(phase))); // R9
endmodule

bind lw_sram lw_sram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .load_n(load_n), .wr_n(wr_n), .out_en_n(out_en_n),
    .dout_oe(dout_oe), .dout(dout), .phase(phase), .cmd_addr(cmd_addr)
);

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [2:0] SEL_OK = 3'b010; // {cs_a_n, cs_b, cs_c_n}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic          cs_c_n = 1'b1;
    logic          load_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_we_n = 2'b11;
    logic          out_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic          dout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard queues: one item per driven cycle
    logic        q_oe[$];
    logic [17:0] q_data[$];
    string       q_tag[$];

    // reference model state built from the requirements
    logic [17:0]   ref_mem [DEPTH];
    int            bm_phase = 0; // 0 idle, 1 read, 2 write
    logic [AW-1:0] bm_addr = '0;

    always #10 clk = ~clk;

    lw_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .load_n(load_n), .wr_n(wr_n), .lane_we_n(lane_we_n),
        .out_en_n(out_en_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // driver: one call per clock cycle
    task automatic step(input logic cen, input logic ld, input logic [2:0] sel,
                        input logic w, input logic [AW-1:0] a, input logic [1:0] bl,
                        input logic [17:0] d, input logic oe_n, input string tag);
        logic        e_oe;
        logic [17:0] e_data;
        @(posedge clk);
        #2;
        clk_en_n = cen; load_n = ld; cs_a_n = sel[2]; cs_b = sel[1]; cs_c_n = sel[0];
        wr_n = w; addr = a; lane_we_n = bl; din = d; out_en_n = oe_n;
        e_oe   = (bm_phase == 1) && !oe_n;
        e_data = e_oe ? ref_mem[bm_addr] : 18'h0;
        q_oe.push_back(e_oe);
        q_data.push_back(e_data);
        q_tag.push_back(tag);
        if (!cen) begin
            if (bm_phase == 2) begin
                if (!bl[0]) ref_mem[bm_addr][8:0]  = d[8:0];
                if (!bl[1]) ref_mem[bm_addr][17:9] = d[17:9];
            end
            if (!ld) begin
                if (sel != SEL_OK) bm_phase = 0;
                else bm_phase = w ? 1 : 2;
            end
            bm_addr = a;
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [1:0] bl, input logic [17:0] d,
                      input logic oe_n, input string tag);
        step(1'b0, 1'b0, SEL_OK, 1'b1, a, bl, d, oe_n, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] bl, input logic [17:0] d,
                      input string tag);
        step(1'b0, 1'b0, SEL_OK, 1'b0, a, bl, d, 1'b0, tag);
    endtask

    task automatic nop(input logic [1:0] bl, input logic [17:0] d, input logic oe_n,
                       input string tag);
        step(1'b0, 1'b0, 3'b000, 1'b1, '0, bl, d, oe_n, tag);
    endtask

    // monitor: compares at mid-cycle
    always @(negedge clk) begin
        if (q_oe.size() > 0) begin
            logic        e_oe;
            logic [17:0] e_data;
            string       t;
            e_oe = q_oe.pop_front();
            e_data = q_data.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (dout_oe !== e_oe || dout !== e_data) begin
                errors++;
                $display("FAIL %s: oe=%0b dout=%05h expected oe=%0b dout=%05h",
                         t, dout_oe, dout, e_oe, e_data);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dout_oe !== 1'b0 || dout !== 18'h0) begin
            errors++;
            $display("FAIL R7 reset: oe=%0b dout=%05h expected oe=0 dout=00000", dout_oe, dout);
        end
        @(posedge clk);
        #2 rst_n = 1'b1;

        // R2 basic write then read
        wr(5, 2'b11, 18'h0, "R7 idle after reset");
        nop(2'b00, 18'h2A5A5, 1'b0, "R6 write phase quiet");
        rd(5, 2'b11, 18'h0, 1'b0, "R7 deselect phase");
        nop(2'b11, 18'h0, 1'b0, "R1 read of address 5");

        // R2 back-to-back alternation, R10 bypass
        wr(6, 2'b11, 18'h0, "R7 idle");
        rd(5, 2'b00, 18'h1C3C3, 1'b0, "R6 write data phase of 6");
        wr(7, 2'b11, 18'h0, "R2 read 5 right after write edge");
        rd(6, 2'b00, 18'h05A5A, 1'b0, "R6 write data phase of 7");
        rd(7, 2'b11, 18'h0, 1'b0, "R10 read 6 after capture");
        nop(2'b11, 18'h0, 1'b0, "R10 read 7 on its data edge");

        // R3 partial writes
        wr(5, 2'b11, 18'h0, "R7 idle");
        nop(2'b10, 18'h3FFFF, 1'b0, "R6 partial write phase");
        rd(5, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R3 lane0 only written");
        wr(5, 2'b11, 18'h0, "R7 idle");
        nop(2'b01, 18'h00000, 1'b0, "R6 partial write phase");
        rd(5, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R3 lane1 only written");

        // R4 abort
        wr(6, 2'b11, 18'h0, "R7 idle");
        nop(2'b11, 18'h3FFFF, 1'b0, "R4 abort phase quiet");
        rd(6, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R4 address 6 unchanged");

        // R5 stall inside write data phase
        wr(8, 2'b11, 18'h0, "R7 idle");
        step(1'b1, 1'b0, SEL_OK, 1'b0, 3, 2'b00, 18'h11111, 1'b0, "R5 stall during write phase");
        nop(2'b00, 18'h2BCDE, 1'b0, "R5 write phase still open");
        rd(8, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R5 stalled edge stored nothing");

        // R5 stall during read
        rd(5, 2'b11, 18'h0, 1'b0, "R7 idle");
        step(1'b1, 1'b0, 3'b000, 1'b1, 9, 2'b11, 18'h0, 1'b0, "R5 read of 5");
        nop(2'b11, 18'h0, 1'b0, "R5 read held across stall");
        nop(2'b11, 18'h0, 1'b0, "R7 idle");

        // R8 output enable
        rd(7, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b1, "R8 output enable high masks read");
        nop(2'b11, 18'h0, 1'b0, "R7 idle");

        // R7 each chip enable deselects
        step(1'b0, 1'b0, 3'b110, 1'b1, 5, 2'b11, 18'h0, 1'b0, "R7 idle");
        step(1'b0, 1'b0, 3'b000, 1'b1, 5, 2'b11, 18'h0, 1'b0, "R7 cs_a_n high deselects");
        step(1'b0, 1'b0, 3'b011, 1'b1, 5, 2'b11, 18'h0, 1'b0, "R7 cs_b low deselects");
        nop(2'b11, 18'h0, 1'b0, "R7 cs_c_n high deselects");

        // R9 continue read
        rd(5, 2'b11, 18'h0, 1'b0, "R7 idle");
        step(1'b0, 1'b1, 3'b000, 1'b0, 6, 2'b11, 18'h0, 1'b0, "R1 read of 5 before continue");
        nop(2'b11, 18'h0, 1'b0, "R9 continued read of 6");

        // R9 continue write
        wr(9, 2'b11, 18'h0, "R7 idle");
        step(1'b0, 1'b1, 3'b000, 1'b1, 10, 2'b00, 18'h12345, 1'b0, "R9 continued write quiet");
        nop(2'b00, 18'h23456, 1'b0, "R9 second write phase quiet");
        rd(9, 2'b11, 18'h0, 1'b0, "R7 idle");
        rd(10, 2'b11, 18'h0, 1'b0, "R9 read of 9");
        nop(2'b11, 18'h0, 1'b0, "R9 read of 10");

        // R9 continue from deselect
        nop(2'b11, 18'h0, 1'b0, "R7 idle");
        step(1'b0, 1'b1, SEL_OK, 1'b1, 5, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R9 continue from idle stays idle");

        // R10 partial merge against buffer, then after commit
        wr(11, 2'b11, 18'h0, "R7 idle");
        nop(2'b00, 18'h0F0F0, 1'b0, "R6 write phase");
        wr(11, 2'b11, 18'h0, "R7 idle");
        rd(11, 2'b10, 18'h155AA, 1'b0, "R6 write phase");
        nop(2'b11, 18'h0, 1'b0, "R10 merged bypass read of 11");
        wr(12, 2'b11, 18'h0, "R7 idle");
        nop(2'b00, 18'h00001, 1'b0, "R6 write phase");
        rd(11, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R10 read of 11 after commit");
        rd(12, 2'b11, 18'h0, 1'b0, "R7 idle");
        nop(2'b11, 18'h0, 1'b0, "R10 read of 12 from buffer");
        nop(2'b11, 18'h0, 1'b0, "R7 idle");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule